// File: doc/BRIEF.md
# Mirrored Register Window Decoder

This block sits on the slave memory-mapped access path of a PCIe controller wrapper. It classifies each access into one of three targets: the controller configuration register space, the address-translation register space, or the ordinary BAR/MMIO target. Both register windows are replicated at every multiple of a programmable period. Inside each period-sized block, each window starts at its own programmable base offset. An access that falls inside a replicated window is steered to that register space, even when the address also belongs to a BAR region.

Software programs three values through a small write port: the period, the configuration-window base and the translation-window base. Writing all ones to the period stretches one block over the whole address space, so each window then appears only once. For every valid access the decoder returns a registered one-hot select and an offset into the chosen space, one cycle later.

Top module: `mirror_window_decoder`

## Requirements
- R1: After reset the period register reads 0x1000000 at config offset 0x16c, the configuration base reads 0x0 at offset 0x168, and the translation base reads 0x1000 at offset 0x170.
- R2: A config write to offset 0x168, 0x16c or 0x170 takes effect on the cycle after the write strobe, and reads return current values combinationally. A write to any other offset changes nothing, and reading any other offset returns 0.
- R3: The in-block offset is the address masked with P-1, where P is the smallest power of two not below the programmed period.
- R4: When the in-block offset lies in [cfg_base, cfg_base+4096), the configuration select is raised. The offset output is the in-block offset minus cfg_base.
- R5: When the in-block offset lies in [xlat_base, xlat_base+4096), the translation select is raised. The offset output is the in-block offset minus xlat_base.
- R6: When both windows contain the in-block offset, the configuration select wins.
- R7: An access that hits neither window raises the BAR select, with the full access address on the offset output.
- R8: The selects and offset are registered and are due one cycle after acc_valid_i. While out_valid_o is high exactly one select is high; otherwise all selects and the offset are 0.
- R9: With the period set to all ones, each window appears only once, at its base, and addresses above the window are routed to BAR.
- R10: After reset out_valid_o, all selects and offset_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_addr_i | input | 12 | Config register offset |
| cfg_wdata_i | input | 32 | Config write data |
| cfg_rdata_o | output | 32 | Config read data for cfg_addr_i |
| acc_valid_i | input | 1 | Access valid |
| acc_addr_i | input | 32 | Access address |
| out_valid_o | output | 1 | Decode result valid |
| sel_cfg_o | output | 1 | Configuration space selected |
| sel_xlat_o | output | 1 | Translation space selected |
| sel_bar_o | output | 1 | BAR/MMIO target selected |
| offset_o | output | 32 | Offset into the selected space |

## Verification
Each decode result is due exactly one clock after acc_valid_i is seen at a rising edge. The bench drives inputs on the falling edge, waits through the next rising edge, and samples at the falling edge that follows. Config writes follow the same pattern: the strobe is applied for one edge, and the read port is sampled after it, since the read path adds no further register. Between probes the valid is dropped, and the idle outputs are checked one cycle later.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  localparam int unsigned CFG_AW = 12;
  localparam logic [CFG_AW-1:0] OFS_CFG_BASE  = 12'h168;
  localparam logic [CFG_AW-1:0] OFS_PERIOD    = 12'h16c;
  localparam logic [CFG_AW-1:0] OFS_XLAT_BASE = 12'h170;

  localparam logic [31:0] RST_PERIOD    = 32'h0100_0000;
  localparam logic [31:0] RST_CFG_BASE  = 32'h0000_0000;
  localparam logic [31:0] RST_XLAT_BASE = 32'h0000_1000;

  typedef enum logic [1:0] {
    TGT_BAR  = 2'd0,
    TGT_CFG  = 2'd1,
    TGT_XLAT = 2'd2
  } tgt_e;
endpackage

// File: rtl/mwd_cfg_regs.sv
module mwd_cfg_regs
  import mwd_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [AW-1:0]     wdata_i,
  output logic [AW-1:0]     rdata_o,
  output logic [AW-1:0]     period_o,
  output logic [AW-1:0]     cfg_base_o,
  output logic [AW-1:0]     xlat_base_o
);
  logic [AW-1:0] period_q, cfg_base_q, xlat_base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q    <= AW'(RST_PERIOD);
      cfg_base_q  <= AW'(RST_CFG_BASE);
      xlat_base_q <= AW'(RST_XLAT_BASE);
    end else if (we_i) begin
      unique case (addr_i)
        OFS_PERIOD:    period_q    <= wdata_i;
        OFS_CFG_BASE:  cfg_base_q  <= wdata_i;
        OFS_XLAT_BASE: xlat_base_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_PERIOD:    rdata_o = period_q;
      OFS_CFG_BASE:  rdata_o = cfg_base_q;
      OFS_XLAT_BASE: rdata_o = xlat_base_q;
      default:       rdata_o = '0;
    endcase
  end

  assign period_o    = period_q;
  assign cfg_base_o  = cfg_base_q;
  assign xlat_base_o = xlat_base_q;

  a_r2_cfg_base_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == OFS_CFG_BASE |=> cfg_base_o == $past(wdata_i));
  a_r2_period_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == OFS_PERIOD |=> period_o == $past(wdata_i));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(period_o) && $stable(cfg_base_o) && $stable(xlat_base_o));
endmodule

// File: rtl/mwd_mask_gen.sv
module mwd_mask_gen #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] period_i,
  output logic [AW-1:0] mask_o
);
  localparam int unsigned STAGES = $clog2(AW);

  logic [AW-1:0] stage [STAGES+1];

  assign stage[0] = period_i - AW'(1);

  // smear highest set bit downward: rounds period up to a power of two
  for (genvar k = 0; k < STAGES; k++) begin : g_smear
    assign stage[k+1] = stage[k] | (stage[k] >> (1 << k));
  end

  assign mask_o = stage[STAGES];

  always_comb begin
    a_r3_mask_contiguous: assert (((mask_o + AW'(1)) & mask_o) == '0);
  end
endmodule

// File: rtl/mwd_window_match.sv
module mwd_window_match #(
  parameter int unsigned AW  = 32,
  parameter int unsigned WIN = 4096
) (
  input  logic [AW-1:0] in_block_i,
  input  logic [AW-1:0] base_i,
  output logic          hit_o,
  output logic [AW-1:0] offset_o
);
  logic [AW-1:0] diff;

  assign diff     = in_block_i - base_i;
  assign hit_o    = (in_block_i >= base_i) && (diff < AW'(WIN));
  assign offset_o = diff;
endmodule

// File: rtl/mirror_window_decoder.sv
module mirror_window_decoder
  import mwd_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned WIN = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [AW-1:0]     cfg_wdata_i,
  output logic [AW-1:0]     cfg_rdata_o,
  input  logic              acc_valid_i,
  input  logic [AW-1:0]     acc_addr_i,
  output logic              out_valid_o,
  output logic              sel_cfg_o,
  output logic              sel_xlat_o,
  output logic              sel_bar_o,
  output logic [AW-1:0]     offset_o
);
  localparam int unsigned NWIN = 2;  // index 0 = config space, 1 = translation space

  logic [AW-1:0] period, cfg_base, xlat_base, mask, in_block;
  logic [AW-1:0] win_base [NWIN];
  logic [AW-1:0] win_ofs  [NWIN];
  logic [NWIN-1:0] win_hit;
  tgt_e          tgt_d;
  logic [AW-1:0] ofs_d;

  mwd_cfg_regs #(.AW(AW)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .rdata_o     (cfg_rdata_o),
    .period_o    (period),
    .cfg_base_o  (cfg_base),
    .xlat_base_o (xlat_base)
  );

  mwd_mask_gen #(.AW(AW)) i_mask (
    .period_i (period),
    .mask_o   (mask)
  );

  assign in_block    = acc_addr_i & mask;
  assign win_base[0] = cfg_base;
  assign win_base[1] = xlat_base;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    mwd_window_match #(.AW(AW), .WIN(WIN)) i_match (
      .in_block_i (in_block),
      .base_i     (win_base[w]),
      .hit_o      (win_hit[w]),
      .offset_o   (win_ofs[w])
    );
  end

  always_comb begin
    if (win_hit[0]) begin
      tgt_d = TGT_CFG;
      ofs_d = win_ofs[0];
    end else if (win_hit[1]) begin
      tgt_d = TGT_XLAT;
      ofs_d = win_ofs[1];
    end else begin
      tgt_d = TGT_BAR;
      ofs_d = acc_addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      sel_cfg_o   <= 1'b0;
      sel_xlat_o  <= 1'b0;
      sel_bar_o   <= 1'b0;
      offset_o    <= '0;
    end else begin
      out_valid_o <= acc_valid_i;
      sel_cfg_o   <= acc_valid_i && (tgt_d == TGT_CFG);
      sel_xlat_o  <= acc_valid_i && (tgt_d == TGT_XLAT);
      sel_bar_o   <= acc_valid_i && (tgt_d == TGT_BAR);
      offset_o    <= acc_valid_i ? ofs_d : '0;
    end
  end

  a_r8_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $onehot({sel_cfg_o, sel_xlat_o, sel_bar_o}));
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> !(sel_cfg_o || sel_xlat_o || sel_bar_o) && offset_o == '0);
  a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> out_valid_o);
  a_r6_cfg_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && (&win_hit) |=> sel_cfg_o);
  a_r7_bar_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && win_hit == '0 |=> sel_bar_o && offset_o == $past(acc_addr_i));
endmodule

// File: tb/test_mirror_window_decoder.sv
module test_mirror_window_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [11:0] cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic        out_valid_o, sel_cfg_o, sel_xlat_o, sel_bar_o;
  logic [31:0] offset_o;

  int checks = 0;
  int failures = 0;
  logic [31:0] m_period, m_cfg, m_xlat;

  always #2 clk_i = ~clk_i;

  mirror_window_decoder i_mirror_window_decoder (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (a == 12'h16c) m_period = d;
    if (a == 12'h168) m_cfg = d;
    if (a == 12'h170) m_xlat = d;
  endtask

  task automatic cfg_read(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk_i);
    cfg_addr_i = a;
    #1 chk(req, {32'h0, cfg_rdata_o}, {32'h0, exp});
  endtask

  // expected: {sel bits cfg,xlat,bar} and offset
  task automatic probe(input string req, input logic [31:0] a, input bit idle_chk);
    logic [32:0] p;
    logic [31:0] inb, d0, d1;
    logic [2:0]  es;
    logic [31:0] eo;
    p = 33'd1;
    while (p < {1'b0, m_period}) p = p << 1;
    inb = a & 32'(p - 33'd1);
    d0 = inb - m_cfg;
    d1 = inb - m_xlat;
    if (inb >= m_cfg && d0 < 32'd4096) begin es = 3'b100; eo = d0; end
    else if (inb >= m_xlat && d1 < 32'd4096) begin es = 3'b010; eo = d1; end
    else begin es = 3'b001; eo = a; end
    @(negedge clk_i);
    acc_valid_i = 1'b1; acc_addr_i = a;
    @(negedge clk_i);
    acc_valid_i = 1'b0;
    chk({req, "_R8_valid"}, {63'h0, out_valid_o}, 64'h1);
    chk(req, {29'h0, sel_cfg_o, sel_xlat_o, sel_bar_o, offset_o}, {29'h0, es, eo});
    if (idle_chk) begin
      @(negedge clk_i);
      chk("R8_idle", {28'h0, out_valid_o, sel_cfg_o, sel_xlat_o, sel_bar_o, offset_o}, 64'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_period = 32'h0100_0000; m_cfg = 32'h0; m_xlat = 32'h1000;
    #1;
    // R10: outputs zero in reset
    chk("R10", {28'h0, out_valid_o, sel_cfg_o, sel_xlat_o, sel_bar_o, offset_o}, 64'h0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset register values
    cfg_read("R1", 12'h16c, 32'h0100_0000);
    cfg_read("R1", 12'h168, 32'h0);
    cfg_read("R1", 12'h170, 32'h1000);
    probe("R1", 32'h0100_0010, 1'b1);
    probe("R1", 32'h0300_1ffc, 1'b1);
    probe("R1", 32'h0100_2000, 1'b0);

    // R2: writes, reads, ignored offsets
    cfg_write(12'h16c, 32'h0000_4000);
    cfg_read("R2", 12'h16c, 32'h0000_4000);
    cfg_write(12'h174, 32'hdead_beef);
    cfg_read("R2", 12'h174, 32'h0);
    cfg_read("R2", 12'h168, 32'h0);
    cfg_read("R2", 12'h170, 32'h1000);
    cfg_read("R2", 12'h16c, 32'h0000_4000);

    // R3 R4 R5 R7: sweep with 16 KiB period
    for (int i = 0; i < 128; i++) probe("R3_R4_R5_R7", 32'(i) * 32'h200 + 32'h4, (i % 16) == 0);

    // R3: non power-of-two period rounds up; R6 overlap gives config priority
    cfg_write(12'h16c, 32'h0000_3000);
    cfg_write(12'h168, 32'h0000_2000);
    cfg_write(12'h170, 32'h0000_2800);
    cfg_read("R2", 12'h170, 32'h2800);
    for (int i = 0; i < 64; i++) probe("R6_R3", 32'h0008_0000 + 32'(i) * 32'h100, 1'b0);

    // R9: all-ones period removes mirroring
    cfg_write(12'h16c, 32'hffff_ffff);
    cfg_write(12'h168, 32'h0);
    cfg_write(12'h170, 32'h1000);
    for (int i = 0; i < 16; i++) probe("R9", 32'(i) * 32'h400, 1'b0);
    probe("R9", 32'h0100_0010, 1'b0);
    probe("R9", 32'h8000_1010, 1'b0);
    probe("R9", 32'hffff_f000, 1'b1);

    // R8: back-to-back valids produce one result per cycle
    @(negedge clk_i);
    acc_valid_i = 1'b1; acc_addr_i = 32'h0000_0020;
    @(negedge clk_i);
    acc_addr_i = 32'h0000_1030;
    chk("R8", {29'h0, sel_cfg_o, sel_xlat_o, sel_bar_o, offset_o}, {29'h0, 3'b100, 32'h20});
    @(negedge clk_i);
    acc_valid_i = 1'b0;
    chk("R8", {29'h0, sel_cfg_o, sel_xlat_o, sel_bar_o, offset_o}, {29'h0, 3'b010, 32'h30});
    @(negedge clk_i);
    chk("R8", {63'h0, out_valid_o}, 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule